// File: doc/BRIEF.md
# Registered Multiplexed Bus Transceiver

This block joins two 8-bit buses, called A and B, through a pair of transfer paths. Each direction has its own storage register and its own capture strobe. The output of each direction can carry either the live value of the opposite bus or the value held in that direction's register. A build parameter sets the data path to pass data through unchanged or to invert it. The same setting applies to both directions.

Neither bus uses tri-state nets. Each side has an external-driver value with its enable, and the block's own drive value with its enable. The block resolves these into a visible bus value for that side. An external driver takes precedence. If there is no external driver, the block's drive is used when it is enabled. If neither is driving, the side keeps its last resolved value, which models a bus that holds its state.

The two drive enables have opposite polarity. The capture strobes are sampled on the system clock, and a register loads on the first clock where its strobe is seen high after being low. Capture does not depend on the selects or enables.

Top module: `reg_bus_xcvr`

## Requirements
- R1: `b_drv_en` equals `en_ab` (active high) and `a_drv_en` equals the inverse of `en_ba_n` (active low). With `en_ab`=0 and `en_ba_n`=1, neither side is driven by the block, and each visible bus shows its external value when one is enabled.
- R2: The A register loads the visible A bus on a clock where `stb_ab` is 1 and was 0 on the previous clock. The B register loads the visible B bus under the same rule using `stb_ba`.
- R3: A register loads whatever values the selects and enables have. A strobe that stays at 1 across clocks causes no further load.
- R4: `b_drv` is P(live A source) when `sel_ab`=0 and P(A register) when `sel_ab`=1. The live A source is `a_ext` when `a_ext_en`=1, and the held A value otherwise.
- R5: `a_drv` is P(live B source) when `sel_ba`=0 and P(B register) when `sel_ba`=1. The live B source is defined the same way, from `b_ext_en`, `b_ext` and the held B value.
- R6: P(x) is x when POLARITY is PATH_PASS and the bitwise inverse of x when POLARITY is PATH_INVERT.
- R7: Each visible bus equals its external value when that side's external enable is 1. Otherwise it equals the block's drive value when the block drives that side. Otherwise it equals the visible value from the previous clock.
- R8: Suppose both directions are enabled, both selects are 0 and no external driver is active, and the buses entered this state from a cycle where one side was driven externally. Then both buses keep the values they had when the external driver let go.
- R9: Raising both strobes on the same clock while one bus is passed in real time to the other stores the same data in both registers. Storing A uses `en_ab`=1, `en_ba_n`=1 and `sel_ab`=0; afterwards the B register holds P(A). Storing B uses `en_ab`=0, `en_ba_n`=0 and `sel_ba`=0; afterwards the A register holds P(B).
- R10: A synchronous active-low reset clears both registers and both held bus values to zero. It also treats both strobes as previously high, so a strobe held at 1 through reset does not load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_ab | input | 1 | Block drives the B side when 1 |
| en_ba_n | input | 1 | Block drives the A side when 0 |
| sel_ab | input | 1 | B output source: 0 live A, 1 A register |
| sel_ba | input | 1 | A output source: 0 live B, 1 B register |
| stb_ab | input | 1 | A register capture strobe, loads on rise |
| stb_ba | input | 1 | B register capture strobe, loads on rise |
| a_ext_en | input | 1 | An external driver is active on the A side |
| a_ext | input | WIDTH | External driver value on the A side |
| b_ext_en | input | 1 | An external driver is active on the B side |
| b_ext | input | WIDTH | External driver value on the B side |
| a_drv_en | output | 1 | Block drives the A side |
| a_drv | output | WIDTH | Block's drive value for the A side |
| b_drv_en | output | 1 | Block drives the B side |
| b_drv | output | WIDTH | Block's drive value for the B side |
| a_bus | output | WIDTH | Resolved visible value of the A side |
| b_bus | output | WIDTH | Resolved visible value of the B side |

## Verification
The hardest state to reach is the self-holding loop. In it, both directions drive in real time and nothing external drives either side. The buses must keep values that were set by a driver that has since let go. The stimulus reaches it in two steps. First, A is driven externally while both directions are enabled, so the opposite side picks up the value. Then the external driver is released, and both buses are watched over several clocks for both polarities. The simultaneous two-strobe store is set up the same way: the data is placed on one bus, the real-time path is opened, and both strobes rise in one clock. The registers are then read back through their stored-data selects.

// File: rtl/rbx_pkg.sv
// Shared types for the registered bus transceiver.
// Assumes: nothing beyond the standard language.
package rbx_pkg;
    // Data-path polarity chosen at build time.
    typedef enum logic {
        PATH_PASS   = 1'b0,
        PATH_INVERT = 1'b1
    } path_e;
endpackage

// File: rtl/rbx_store_reg.sv
// One direction's storage register with rising-strobe capture.
// Assumes: the strobe is synchronous to clk; a rise is a clock
// where the strobe is 1 and was 0 on the previous clock. Capture
// depends on nothing else.
module rbx_store_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic [WIDTH-1:0] d,
    output logic             cap,
    output logic [WIDTH-1:0] q
);
    logic stb_q;

    assign cap = stb & ~stb_q;

    // Remember the strobe level; reset treats it as already high.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b1;
        else        stb_q <= stb;
    end

    // Load the register on a detected strobe rise.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (cap) q <= d;
    end

    // R2
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (q == $past(d)));

    // R3
    no_rise_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(q));
endmodule

// File: rtl/rbx_bus_side.sv
// Resolves one bus side from its external driver, the block's drive
// and a hold register that keeps the last resolved value.
// Assumes: an external driver wins over the block's drive. The
// live source passed to the opposite direction never uses this
// side's own block drive, so no combinational loop forms.
module rbx_bus_side #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_en,
    input  logic [WIDTH-1:0] ext_val,
    input  logic             drv_en,
    input  logic [WIDTH-1:0] drv_val,
    output logic [WIDTH-1:0] bus,
    output logic [WIDTH-1:0] src
);
    logic [WIDTH-1:0] hold_q;

    // Live value offered to the opposite direction.
    always_comb begin
        src = ext_en ? ext_val : hold_q;
    end

    // Visible value of this side with drive priority applied.
    always_comb begin
        if (ext_en)      bus = ext_val;
        else if (drv_en) bus = drv_val;
        else             bus = hold_q;
    end

    // Bus-hold register tracking the last visible value.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= bus;
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ext_en && !drv_en) |-> (bus == $past(bus)));
endmodule

// File: rtl/rbx_path_mux.sv
// Chooses live or stored data for one direction and applies the
// build-time polarity.
// Assumes: sel=0 picks live, sel=1 picks stored.
module rbx_path_mux
    import rbx_pkg::*;
#(
    parameter int unsigned WIDTH    = 8,
    parameter path_e       POLARITY = PATH_PASS
) (
    input  logic             sel,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] out
);
    logic [WIDTH-1:0] pick;

    // Source selection between live and stored data.
    always_comb begin
        pick = sel ? stored : live;
    end

    // Polarity stage picked by the build parameter.
    generate
        if (POLARITY == PATH_INVERT) begin : g_inv
            assign out = ~pick;
        end else begin : g_pass
            assign out = pick;
        end
    endgenerate
endmodule

// File: rtl/reg_bus_xcvr.sv
// Registered multiplexed bus transceiver between buses A and B.
// Assumes: both sides are modelled as split ports. en_ab is active
// high and en_ba_n is active low. Both registers capture on their
// strobe rises regardless of selects and enables.
module reg_bus_xcvr
    import rbx_pkg::*;
#(
    parameter int unsigned WIDTH    = 8,
    parameter path_e       POLARITY = PATH_PASS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_ab,
    input  logic             en_ba_n,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic             stb_ab,
    input  logic             stb_ba,
    input  logic             a_ext_en,
    input  logic [WIDTH-1:0] a_ext,
    input  logic             b_ext_en,
    input  logic [WIDTH-1:0] b_ext,
    output logic             a_drv_en,
    output logic [WIDTH-1:0] a_drv,
    output logic             b_drv_en,
    output logic [WIDTH-1:0] b_drv,
    output logic [WIDTH-1:0] a_bus,
    output logic [WIDTH-1:0] b_bus
);
    localparam logic [WIDTH-1:0] FLIP = (POLARITY == PATH_INVERT) ? '1 : '0;

    logic [WIDTH-1:0] a_src, b_src;
    logic [WIDTH-1:0] reg_a, reg_b;
    logic             cap_a, cap_b;

    // Drive enables with their opposite polarities.
    always_comb begin
        b_drv_en = en_ab;
        a_drv_en = ~en_ba_n;
    end

    rbx_bus_side #(.WIDTH(WIDTH)) u_side_a (
        .clk(clk), .rst_n(rst_n),
        .ext_en(a_ext_en), .ext_val(a_ext),
        .drv_en(a_drv_en), .drv_val(a_drv),
        .bus(a_bus), .src(a_src)
    );

    rbx_bus_side #(.WIDTH(WIDTH)) u_side_b (
        .clk(clk), .rst_n(rst_n),
        .ext_en(b_ext_en), .ext_val(b_ext),
        .drv_en(b_drv_en), .drv_val(b_drv),
        .bus(b_bus), .src(b_src)
    );

    rbx_store_reg #(.WIDTH(WIDTH)) u_reg_a (
        .clk(clk), .rst_n(rst_n), .stb(stb_ab),
        .d(a_bus), .cap(cap_a), .q(reg_a)
    );

    rbx_store_reg #(.WIDTH(WIDTH)) u_reg_b (
        .clk(clk), .rst_n(rst_n), .stb(stb_ba),
        .d(b_bus), .cap(cap_b), .q(reg_b)
    );

    rbx_path_mux #(.WIDTH(WIDTH), .POLARITY(POLARITY)) u_mux_ab (
        .sel(sel_ab), .live(a_src), .stored(reg_a), .out(b_drv)
    );

    rbx_path_mux #(.WIDTH(WIDTH), .POLARITY(POLARITY)) u_mux_ba (
        .sel(sel_ba), .live(b_src), .stored(reg_b), .out(a_drv)
    );

    // R9
    dual_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_a && cap_b && en_ab && en_ba_n && !sel_ab && !b_ext_en)
        |=> (reg_b == (reg_a ^ FLIP)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (reg_a == '0 && reg_b == '0));
endmodule

// File: tb/reg_bus_xcvr_test.sv
module reg_bus_xcvr_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_ab = 0, en_ba_n = 1, sel_ab = 0, sel_ba = 0;
    logic stb_ab = 0, stb_ba = 0, a_ext_en = 0, b_ext_en = 0;
    logic [7:0] a_ext = 0, b_ext = 0;

    logic       a_drv_en_w [2];
    logic       b_drv_en_w [2];
    logic [7:0] a_drv_w [2];
    logic [7:0] b_drv_w [2];
    logic [7:0] a_bus_w [2];
    logic [7:0] b_bus_w [2];

    int checks = 0;
    int fails  = 0;

    // model state per instance (0 pass, 1 invert)
    logic [7:0] ma [2];
    logic [7:0] mb [2];
    logic [7:0] ha [2];
    logic [7:0] hb [2];
    logic       pa [2];
    logic       pb [2];
    logic [7:0] ea_bus [2];
    logic [7:0] eb_bus [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_bus_xcvr #(.WIDTH(8), .POLARITY(rbx_pkg::PATH_PASS)) uut (
        .clk(clk), .rst_n(rst_n), .en_ab(en_ab), .en_ba_n(en_ba_n),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .stb_ab(stb_ab), .stb_ba(stb_ba),
        .a_ext_en(a_ext_en), .a_ext(a_ext), .b_ext_en(b_ext_en), .b_ext(b_ext),
        .a_drv_en(a_drv_en_w[0]), .a_drv(a_drv_w[0]),
        .b_drv_en(b_drv_en_w[0]), .b_drv(b_drv_w[0]),
        .a_bus(a_bus_w[0]), .b_bus(b_bus_w[0])
    );

    reg_bus_xcvr #(.WIDTH(8), .POLARITY(rbx_pkg::PATH_INVERT)) uut_inv (
        .clk(clk), .rst_n(rst_n), .en_ab(en_ab), .en_ba_n(en_ba_n),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .stb_ab(stb_ab), .stb_ba(stb_ba),
        .a_ext_en(a_ext_en), .a_ext(a_ext), .b_ext_en(b_ext_en), .b_ext(b_ext),
        .a_drv_en(a_drv_en_w[1]), .a_drv(a_drv_w[1]),
        .b_drv_en(b_drv_en_w[1]), .b_drv(b_drv_w[1]),
        .a_bus(a_bus_w[1]), .b_bus(b_bus_w[1])
    );

    // R6: polarity transform
    function automatic logic [7:0] pth(input int i, input logic [7:0] x);
        return (i == 1) ? ~x : x;
    endfunction

    task automatic chk(input string tag, input int i, input logic [7:0] got,
                       input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s inst%0d got %h expected %h", tag, i, got, exp);
        end
    endtask

    // Compare all outputs with the model, then advance one clock.
    task automatic run_cycle();
        #1;
        for (int i = 0; i < 2; i++) begin
            logic [7:0] asrc, bsrc, adrv, bdrv;
            asrc = a_ext_en ? a_ext : ha[i];
            bsrc = b_ext_en ? b_ext : hb[i];
            bdrv = pth(i, sel_ab ? ma[i] : asrc);
            adrv = pth(i, sel_ba ? mb[i] : bsrc);
            ea_bus[i] = a_ext_en ? a_ext : (!en_ba_n ? adrv : ha[i]);
            eb_bus[i] = b_ext_en ? b_ext : (en_ab ? bdrv : hb[i]);
            chk("R1 a_drv_en", i, {7'd0, a_drv_en_w[i]}, {7'd0, ~en_ba_n});
            chk("R1 b_drv_en", i, {7'd0, b_drv_en_w[i]}, {7'd0, en_ab});
            chk("R4 R2 R6 b_drv", i, b_drv_w[i], bdrv);
            chk("R5 R3 R6 a_drv", i, a_drv_w[i], adrv);
            chk("R7 a_bus", i, a_bus_w[i], ea_bus[i]);
            chk("R7 b_bus", i, b_bus_w[i], eb_bus[i]);
        end
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            if (stb_ab && !pa[i]) ma[i] = ea_bus[i];
            if (stb_ba && !pb[i]) mb[i] = eb_bus[i];
            pa[i] = stb_ab;
            pb[i] = stb_ba;
            ha[i] = ea_bus[i];
            hb[i] = eb_bus[i];
        end
        @(negedge clk);
    endtask

    task automatic set_ctl(input logic e_ab, input logic e_ba_n, input logic s_ab,
                           input logic s_ba, input logic x_a, input logic x_b);
        en_ab = e_ab; en_ba_n = e_ba_n; sel_ab = s_ab; sel_ba = s_ba;
        a_ext_en = x_a; b_ext_en = x_b;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        stb_ab = 1; stb_ba = 1;
        repeat (3) @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            ma[i] = 0; mb[i] = 0; ha[i] = 0; hb[i] = 0; pa[i] = 1; pb[i] = 1;
        end
        @(negedge clk);
        rst_n = 1;

        // R10: cleared registers, strobes held high through reset do not load
        set_ctl(1, 0, 1, 1, 0, 0);
        a_ext = 8'hC3; b_ext = 8'h3C;
        run_cycle();
        #1;
        for (int i = 0; i < 2; i++) begin
            chk("R10 b_drv after reset", i, b_drv_w[i], pth(i, 8'h00));
            chk("R10 a_drv after reset", i, a_drv_w[i], pth(i, 8'h00));
        end
        stb_ab = 0; stb_ba = 0;
        run_cycle();

        // R1: isolation, buses show external values
        set_ctl(0, 1, 0, 0, 1, 1);
        a_ext = 8'h12; b_ext = 8'h34;
        #1;
        for (int i = 0; i < 2; i++) begin
            chk("R1 isolation a_bus", i, a_bus_w[i], 8'h12);
            chk("R1 isolation b_bus", i, b_bus_w[i], 8'h34);
        end
        run_cycle();

        // R2 R3: capture while isolated, then no reload while strobe stays high
        a_ext = 8'h11; stb_ab = 1;
        run_cycle();
        a_ext = 8'h22;
        run_cycle();
        set_ctl(1, 1, 1, 0, 1, 0);
        #1;
        for (int i = 0; i < 2; i++)
            chk("R3 held strobe no reload", i, b_drv_w[i], pth(i, 8'h11));
        run_cycle();
        stb_ab = 0;
        run_cycle();

        // R9: store A in both registers with simultaneous strobes
        set_ctl(1, 1, 0, 0, 1, 0);
        a_ext = 8'h3C; stb_ab = 0; stb_ba = 0;
        run_cycle();
        stb_ab = 1; stb_ba = 1;
        run_cycle();
        stb_ab = 0; stb_ba = 0;
        set_ctl(1, 0, 1, 1, 0, 0);
        #1;
        for (int i = 0; i < 2; i++) begin
            chk("R9 A stored in A reg", i, b_drv_w[i], pth(i, 8'h3C));
            chk("R9 A stored in B reg", i, a_drv_w[i], 8'h3C);
        end
        run_cycle();

        // R9: store B in both registers
        set_ctl(0, 0, 0, 0, 0, 1);
        b_ext = 8'hA1;
        run_cycle();
        stb_ab = 1; stb_ba = 1;
        run_cycle();
        stb_ab = 0; stb_ba = 0;
        set_ctl(1, 0, 1, 1, 0, 0);
        #1;
        for (int i = 0; i < 2; i++) begin
            chk("R9 B stored in B reg", i, a_drv_w[i], pth(i, 8'hA1));
            chk("R9 B stored in A reg", i, b_drv_w[i], 8'hA1);
        end
        run_cycle();

        // R8: bus-hold loop after the external A driver lets go
        set_ctl(1, 0, 0, 0, 1, 0);
        a_ext = 8'h5A;
        run_cycle();
        a_ext_en = 0;
        for (int n = 0; n < 6; n++) begin
            #1;
            for (int i = 0; i < 2; i++) begin
                chk("R8 loop a_bus", i, a_bus_w[i], 8'h5A);
                chk("R8 loop b_bus", i, b_bus_w[i], pth(i, 8'h5A));
            end
            run_cycle();
        end

        // Sweep every control combination with varied data and strobes
        for (int c = 0; c < 64; c++) begin
            for (int k = 0; k < 16; k++) begin
                set_ctl(c[0], c[1], c[2], c[3], c[4], c[5]);
                a_ext = 8'($urandom); b_ext = 8'($urandom);
                stb_ab = 1'($urandom); stb_ba = 1'($urandom);
                run_cycle();
            end
        end

        // Free random run
        for (int n = 0; n < 2000; n++) begin
            set_ctl(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom));
            a_ext = 8'($urandom); b_ext = 8'($urandom);
            stb_ab = 1'($urandom); stb_ba = 1'($urandom);
            run_cycle();
        end

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule